// File: doc/BRIEF.md
# Clock Output Mode and Power-Down Controller

This block is the digital control core of a multi-output system clock generator. It drives four groups of clock outputs: a set of differential host pairs, one IO clock, a pair of 48 MHz clocks and one reference clock. The phase-locked loops, oscillator, current-mode drivers and spread modulator sit outside it. Each group's clock comes in on an input pin. For each group the block produces a drive code, a frequency choice where one applies, a pad output enable and a gated copy of that group's clock.

Three configuration straps share pins with the 48 MHz and reference outputs. While those pins are still inputs, the block samples the straps once, on the first reference-clock edge after reset. The captured straps and the host-speed select together form a 4-bit configuration code. That code selects normal running, Hi-Z groups, forced-low groups, a 200 MHz host row, debug rows or a test-clock mode. An active-low power-down request stops the IO, 48 MHz and reference clocks and parks the host pairs. It passes through a synchronizer into each group's clock domain. The gate enable lands only while that group's clock is low, so no output pulse is ever cut short. An active-low spread request is registered and passed on to the synthesizer of the host and IO clocks.

All pins are plain control and clock signals. There is no streaming data path and so no valid/ready handshake.

Top module: `clkgen_ctrl`

## Requirements
- R1: Strap pins are captured on the first rising edge of `ref_clk` after `rst_n` is released, with `strap_i[2]`=A, `strap_i[1]`=B, `strap_i[0]`=C. They are held until the next reset, and later changes on `strap_i` do not affect any output.
- R2: During reset and before the strap capture, every drive code is Hi-Z (00), every pad enable is 0 and every gated clock output is low. Pad enables `io_oe`, `usb_oe` and `ref_oe` are 1 exactly when the group's drive code is not Hi-Z.
- R3: The configuration code is {`speed_sel`,A,B,C}. Drive codes are 00 Hi-Z, 01 forced low, 10 run and 11 test. Host rate codes are 00 for 100 MHz, 01 for 133 MHz and 10 for 200 MHz; the rate reads 00 unless the host drive is run. `io_fast_o`=1 means 66.7 MHz and reads 0 unless the IO drive is run. Codes x00C set every group to run, with host rate 01 if `speed_sel`=1 and 00 otherwise, and with `io_fast_o`=C.
- R4: Codes x01C are the same as R3, except that the 48 MHz group is Hi-Z.
- R5: Code 0100 gives host run at 00, 48 MHz Hi-Z, and IO and reference forced low. Code 1100 gives host run at 10, with all other groups running and `io_fast_o`=0.
- R6: Code 0110 gives host forced low and the IO, 48 MHz and reference groups Hi-Z.
- R7: Code 1110 puts every group in test drive (11). This means host at test clock/2, 48 MHz and IO at test clock/4, and reference at the test clock directly.
- R8: Debug codes x101 and x111 run every group, with the host rate as in R3 and `io_fast_o`=C.
- R9: While power-down is in effect, the IO, 48 MHz and reference gated clocks stay low. For a host group in run or test drive, `host_hold_o`=1 and `host_bar_oe`=0; in normal operation `host_hold_o`=0 and `host_bar_oe`=1.
- R10: Suppose `pwrdn_n` is sampled at rising edge n of a group clock. The gate enable of that group takes this value at the falling edge after edge n+1, and the high phase after edge n+2 is the first one that shows it. Enables change only while the group clock is low.
- R11: `sys_spread_o` equals the inverse of `spread_n` as sampled at the previous `ref_clk` rising edge, and is 0 in reset. It is the only spread request; the 48 MHz and reference groups have none.
- R12: A group whose drive code is forced low or Hi-Z never pulses its gated clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference-group clock; captures the straps and spread request |
| host_clk | input | 1 | Host-group clock |
| io_clk | input | 1 | IO-group clock |
| usb_clk | input | 1 | 48 MHz-group clock |
| strap_i | input | 3 | Strap pin inputs {A,B,C} |
| speed_sel | input | 1 | Host-speed select, part of the configuration code |
| pwrdn_n | input | 1 | Active-low power-down request |
| spread_n | input | 1 | Active-low spread request |
| host_ck_o | output | NUM_HOST | Gated host clocks, true leg |
| host_hold_o | output | 1 | True legs held at fixed drive during power-down |
| host_bar_oe | output | 1 | Complementary legs driven |
| host_drv_o | output | 2 | Host drive code |
| host_rate_o | output | 2 | Host rate code |
| io_ck_o | output | 1 | Gated IO clock |
| io_oe | output | 1 | IO pad enable |
| io_drv_o | output | 2 | IO drive code |
| io_fast_o | output | 1 | IO at 66.7 MHz |
| usb_ck_o | output | NUM_USB | Gated 48 MHz clocks |
| usb_oe | output | 1 | 48 MHz pad enable (0 while strapping) |
| usb_drv_o | output | 2 | 48 MHz drive code |
| ref_ck_o | output | 1 | Gated reference clock |
| ref_oe | output | 1 | Reference pad enable (0 while strapping) |
| ref_drv_o | output | 2 | Reference drive code |
| sys_spread_o | output | 1 | Spread request to the host/IO synthesizer |

## Verification
The drive codes, rate, IO speed and pad enables become valid in the same `ref_clk` cycle as the capturing edge. The spread output follows one `ref_clk` edge later. A gated clock output reflects the power-down request from two rising edges earlier, so the earliest change appears in the high phase after edge n+2. The bench ties every group clock to its single clock and samples 1 ns after each rising edge, while the clocks are high. Its model pipes the sampled requests through a three-entry history and compares each output against the entry due for that edge. Power-down pulses as short as one cycle test the pipeline alignment, and strap pins are inverted after capture to show that they are ignored.

// File: rtl/clkgen_ctrl_pkg.sv
`timescale 1ns/1ps
package clkgen_ctrl_pkg;

  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_RUN  = 2'b10,
    DRV_TEST = 2'b11
  } drive_e;

  typedef enum logic [1:0] {
    HR_100 = 2'b00,
    HR_133 = 2'b01,
    HR_200 = 2'b10
  } host_rate_e;

  typedef struct packed {
    drive_e     hst;
    host_rate_e hrate;
    drive_e     ioc;
    logic       io_fast;
    drive_e     usbc;
    drive_e     refc;
  } mode_t;

  localparam int STRAP_W = 3;

  function automatic logic clocks_on(drive_e d);
    return (d == DRV_RUN) || (d == DRV_TEST);
  endfunction

endpackage

// File: rtl/clkgen_strap_latch.sv
`timescale 1ns/1ps
module clkgen_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] held_o,
  output logic         done_o
);

  // one-shot capture: first edge after reset, then frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      held_o <= pins_i;
      done_o <= 1'b1;
    end
  end

endmodule

// File: rtl/clkgen_mode_decode.sv
`timescale 1ns/1ps
module clkgen_mode_decode
  import clkgen_ctrl_pkg::*;
(
  input  logic         valid_i,
  input  logic [2:0]   sel_i,
  input  logic         fast_host_i,
  output mode_t        mode_o
);

  logic sa, sb, sc;
  assign sa = sel_i[2];
  assign sb = sel_i[1];
  assign sc = sel_i[0];

  always_comb begin
    mode_o = '{hst: DRV_HIZ, hrate: HR_100, ioc: DRV_HIZ, io_fast: 1'b0,
               usbc: DRV_HIZ, refc: DRV_HIZ};
    if (valid_i) begin
      mode_o.hst     = DRV_RUN;
      mode_o.hrate   = fast_host_i ? HR_133 : HR_100;
      mode_o.ioc     = DRV_RUN;
      mode_o.io_fast = sc;
      mode_o.usbc    = DRV_RUN;
      mode_o.refc    = DRV_RUN;
      case ({sa, sb, sc})
        3'b010, 3'b011: mode_o.usbc = DRV_HIZ;
        3'b100: begin
          mode_o.io_fast = 1'b0;
          if (fast_host_i) begin
            mode_o.hrate = HR_200;
          end else begin
            mode_o.hrate = HR_100;
            mode_o.usbc  = DRV_HIZ;
            mode_o.ioc   = DRV_LOW;
            mode_o.refc  = DRV_LOW;
          end
        end
        3'b110: begin
          if (fast_host_i) begin
            mode_o.hst  = DRV_TEST;
            mode_o.ioc  = DRV_TEST;
            mode_o.usbc = DRV_TEST;
            mode_o.refc = DRV_TEST;
          end else begin
            mode_o.hst  = DRV_LOW;
            mode_o.ioc  = DRV_HIZ;
            mode_o.usbc = DRV_HIZ;
            mode_o.refc = DRV_HIZ;
          end
        end
        default: ;
      endcase
      // frequency fields only carry meaning in run drive
      if (mode_o.hst != DRV_RUN) mode_o.hrate = HR_100;
      if (mode_o.ioc != DRV_RUN) mode_o.io_fast = 1'b0;
    end
  end

endmodule

// File: rtl/clkgen_gate_sync.sv
`timescale 1ns/1ps
module clkgen_gate_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] en_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= req_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  // land on the falling edge so the gate only moves while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= stage_q[LAST];
  end

endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int NUM_HOST    = 8,
  parameter int NUM_USB     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rst_n,
  input  logic                ref_clk,
  input  logic                host_clk,
  input  logic                io_clk,
  input  logic                usb_clk,
  input  logic [2:0]          strap_i,
  input  logic                speed_sel,
  input  logic                pwrdn_n,
  input  logic                spread_n,
  output logic [NUM_HOST-1:0] host_ck_o,
  output logic                host_hold_o,
  output logic                host_bar_oe,
  output logic [1:0]          host_drv_o,
  output logic [1:0]          host_rate_o,
  output logic                io_ck_o,
  output logic                io_oe,
  output logic [1:0]          io_drv_o,
  output logic                io_fast_o,
  output logic [NUM_USB-1:0]  usb_ck_o,
  output logic                usb_oe,
  output logic [1:0]          usb_drv_o,
  output logic                ref_ck_o,
  output logic                ref_oe,
  output logic [1:0]          ref_drv_o,
  output logic                sys_spread_o
);

  logic [STRAP_W-1:0] strap_q;
  logic               strap_done;
  mode_t              mode;
  logic               run_req;
  logic [1:0]         host_req, host_state;
  logic               host_en, io_en, usb_en, ref_en;

  clkgen_strap_latch #(.W(STRAP_W)) u_straps (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .pins_i (strap_i),
    .held_o (strap_q),
    .done_o (strap_done)
  );

  clkgen_mode_decode u_decode (
    .valid_i     (strap_done),
    .sel_i       (strap_q),
    .fast_host_i (speed_sel),
    .mode_o      (mode)
  );

  assign run_req  = strap_done & pwrdn_n;
  assign host_req = {strap_done & ~pwrdn_n & clocks_on(mode.hst),
                     run_req & clocks_on(mode.hst)};

  // hold and enable travel together so they swap on one falling edge
  clkgen_gate_sync #(.W(2), .STAGES(SYNC_STAGES)) u_host_sync (
    .clk (host_clk), .rst_n (rst_n), .req_i (host_req), .en_o (host_state)
  );
  clkgen_gate_sync #(.W(1), .STAGES(SYNC_STAGES)) u_io_sync (
    .clk (io_clk), .rst_n (rst_n),
    .req_i (run_req & clocks_on(mode.ioc)), .en_o (io_en)
  );
  clkgen_gate_sync #(.W(1), .STAGES(SYNC_STAGES)) u_usb_sync (
    .clk (usb_clk), .rst_n (rst_n),
    .req_i (run_req & clocks_on(mode.usbc)), .en_o (usb_en)
  );
  clkgen_gate_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_sync (
    .clk (ref_clk), .rst_n (rst_n),
    .req_i (run_req & clocks_on(mode.refc)), .en_o (ref_en)
  );

  assign host_en     = host_state[0];
  assign host_hold_o = host_state[1];
  assign host_bar_oe = host_en;

  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host_gate
    assign host_ck_o[h] = host_clk & host_en;
  end
  for (genvar u = 0; u < NUM_USB; u++) begin : g_usb_gate
    assign usb_ck_o[u] = usb_clk & usb_en;
  end
  assign io_ck_o  = io_clk & io_en;
  assign ref_ck_o = ref_clk & ref_en;

  assign host_drv_o  = mode.hst;
  assign host_rate_o = mode.hrate;
  assign io_drv_o    = mode.ioc;
  assign io_fast_o   = mode.io_fast;
  assign usb_drv_o   = mode.usbc;
  assign ref_drv_o   = mode.refc;
  assign io_oe       = (mode.ioc  != DRV_HIZ);
  assign usb_oe      = (mode.usbc != DRV_HIZ);
  assign ref_oe      = (mode.refc != DRV_HIZ);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sys_spread_o <= 1'b0;
    else        sys_spread_o <= ~spread_n;
  end

endmodule

// File: rtl/clkgen_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_ctrl_chk (
  input logic       rst_n,
  input logic       ref_clk,
  input logic       host_clk,
  input logic       io_clk,
  input logic       pwrdn_n,
  input logic       spread_n,
  input logic       strap_done,
  input logic [2:0] strap_q,
  input logic       host_en,
  input logic       io_en,
  input logic       host_hold_o,
  input logic       host_bar_oe,
  input logic       usb_oe,
  input logic       ref_oe,
  input logic       sys_spread_o
);

  // R1
  strap_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    strap_done |=> strap_done);

  // R1
  strap_frozen_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_q));

  // R2
  pads_input_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !strap_done |-> (!usb_oe && !ref_oe));

  // R9
  host_pd_bar_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
    !$past(pwrdn_n, 2) |-> !host_bar_oe);

  // R9
  host_run_hold_chk: assert property (@(posedge host_clk) disable iff (!rst_n)
    $past(pwrdn_n, 2) |-> !host_hold_o);

  // R9
  io_pd_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
    !$past(pwrdn_n, 2) |-> !io_en);

  // R11
  spread_follow_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(rst_n) |-> (sys_spread_o == !$past(spread_n)));

  // R10
  always @(host_en) begin
    if (rst_n) host_gate_low_chk: assert (host_clk == 1'b0);
  end

  // R10
  always @(io_en) begin
    if (rst_n) io_gate_low_chk: assert (io_clk == 1'b0);
  end

endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (.*);

// File: tb/clkgen_ctrl_bench.sv
`timescale 1ns/1ps
module clkgen_ctrl_bench;
  localparam int NH = 8;
  localparam int NU = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [2:0]    strap_i = 3'b000;
  logic          speed_sel = 1'b0, pwrdn_n = 1'b1, spread_n = 1'b1;
  logic [NH-1:0] host_ck_o;
  logic          host_hold_o, host_bar_oe, io_ck_o, io_oe, io_fast_o;
  logic [1:0]    host_drv_o, host_rate_o, io_drv_o, usb_drv_o, ref_drv_o;
  logic [NU-1:0] usb_ck_o;
  logic          usb_oe, ref_ck_o, ref_oe, sys_spread_o;

  clkgen_ctrl #(.NUM_HOST(NH), .NUM_USB(NU), .SYNC_STAGES(2)) u_clkgen_ctrl (
    .rst_n(rst_n), .ref_clk(clk), .host_clk(clk), .io_clk(clk), .usb_clk(clk),
    .strap_i(strap_i), .speed_sel(speed_sel), .pwrdn_n(pwrdn_n), .spread_n(spread_n),
    .host_ck_o(host_ck_o), .host_hold_o(host_hold_o), .host_bar_oe(host_bar_oe),
    .host_drv_o(host_drv_o), .host_rate_o(host_rate_o),
    .io_ck_o(io_ck_o), .io_oe(io_oe), .io_drv_o(io_drv_o), .io_fast_o(io_fast_o),
    .usb_ck_o(usb_ck_o), .usb_oe(usb_oe), .usb_drv_o(usb_drv_o),
    .ref_ck_o(ref_ck_o), .ref_oe(ref_oe), .ref_drv_o(ref_drv_o),
    .sys_spread_o(sys_spread_o)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R2";

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // packed: [10:9] host drv, [8:7] host rate, [6:5] io drv, [4] io fast,
  //         [3:2] usb drv, [1:0] ref drv
  function automatic logic [10:0] table_m(bit dn, logic [2:0] s, logic spd);
    logic [1:0] hr;
    hr = spd ? 2'b01 : 2'b00;
    if (!dn) return 11'd0;
    casez ({spd, s})
      4'b?00?: return {2'b10, hr, 2'b10, s[0], 2'b10, 2'b10};
      4'b?01?: return {2'b10, hr, 2'b10, s[0], 2'b00, 2'b10};
      4'b0100: return {2'b10, 2'b00, 2'b01, 1'b0, 2'b00, 2'b01};
      4'b1100: return {2'b10, 2'b10, 2'b10, 1'b0, 2'b10, 2'b10};
      4'b0110: return {2'b01, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
      4'b1110: return {2'b11, 2'b00, 2'b11, 1'b0, 2'b11, 2'b11};
      default: return {2'b10, hr, 2'b10, s[0], 2'b10, 2'b10};
    endcase
  endfunction

  function automatic bit act_m(logic [1:0] d);
    return d[1];
  endfunction

  bit         done_m = 0;
  logic [2:0] straps_m = 3'b000;
  logic       spread_m = 1'b0;
  logic [4:0] hist[$];

  task automatic step();
    logic [10:0] pre, post;
    logic [4:0]  req, e;
    string       tag;
    if (!rst_n) begin
      done_m = 0; straps_m = 3'b000; spread_m = 1'b0; hist.delete();
    end else begin
      pre = table_m(done_m, straps_m, speed_sel);
      req[0] = done_m & pwrdn_n & act_m(pre[10:9]);
      req[1] = done_m & !pwrdn_n & act_m(pre[10:9]);
      req[2] = done_m & pwrdn_n & act_m(pre[6:5]);
      req[3] = done_m & pwrdn_n & act_m(pre[3:2]);
      req[4] = done_m & pwrdn_n & act_m(pre[1:0]);
      hist.push_back(req);
      if (hist.size() > 3) void'(hist.pop_front());
      if (!done_m) begin straps_m = strap_i; done_m = 1; end
      spread_m = !spread_n;
    end
    post = table_m(done_m, straps_m, speed_sel);
    e    = (hist.size() == 3) ? hist[0] : 5'd0;
    tag  = rst_n ? cur_tag : "R2";
    chk(tag, "host_drv", 16'(host_drv_o), 16'(post[10:9]));
    chk(tag, "host_rate", 16'(host_rate_o), 16'(post[8:7]));
    chk(tag, "io_drv", 16'(io_drv_o), 16'(post[6:5]));
    chk(tag, "io_fast", 16'(io_fast_o), 16'(post[4]));
    chk(tag, "usb_drv", 16'(usb_drv_o), 16'(post[3:2]));
    chk(tag, "ref_drv", 16'(ref_drv_o), 16'(post[1:0]));
    chk("R2", "io_oe", 16'(io_oe), 16'(post[6:5] != 2'b00));
    chk("R2", "usb_oe", 16'(usb_oe), 16'(post[3:2] != 2'b00));
    chk("R2", "ref_oe", 16'(ref_oe), 16'(post[1:0] != 2'b00));
    chk("R10", "host_ck", 16'(host_ck_o), 16'({NH{e[0]}}));
    chk("R10", "io_ck", 16'(io_ck_o), 16'(e[2]));
    chk("R10", "usb_ck", 16'(usb_ck_o), 16'({NU{e[3]}}));
    chk("R10", "ref_ck", 16'(ref_ck_o), 16'(e[4]));
    chk("R9", "host_bar_oe", 16'(host_bar_oe), 16'(e[0]));
    chk("R9", "host_hold", 16'(host_hold_o), 16'(e[1]));
    chk("R11", "spread", 16'(sys_spread_o), 16'(spread_m));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      step();
    end
  end

  task automatic run_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scenario(string tag, logic [3:0] code, bit pd_first);
    logic [10:0] want;
    @(negedge clk);
    rst_n = 1'b0; strap_i = code[2:0]; speed_sel = code[3];
    pwrdn_n = !pd_first; spread_n = 1'b1;
    run_cycles(3);
    // R2: reset state seen at the ports
    chk("R2", "drv in reset", 16'({host_drv_o, io_drv_o, usb_drv_o, ref_drv_o}), 16'd0);
    chk("R2", "oe in reset", 16'({io_oe, usb_oe, ref_oe, host_bar_oe}), 16'd0);
    cur_tag = tag;
    rst_n = 1'b1;
    run_cycles(1);
    strap_i = ~code[2:0];            // pins now outputs; must be ignored
    run_cycles(6);
    pwrdn_n = 1'b0; spread_n = 1'b0;
    run_cycles(6);
    pwrdn_n = 1'b1;
    run_cycles(2);
    pwrdn_n = 1'b0;
    run_cycles(1);
    pwrdn_n = 1'b1; spread_n = 1'b1;
    run_cycles(6);
    want = table_m(1, code[2:0], code[3]);
    // R1: captured straps still in force after the pins changed
    chk("R1", "host_drv held", 16'(host_drv_o), 16'(want[10:9]));
    chk("R1", "io_drv held", 16'(io_drv_o), 16'(want[6:5]));
    chk("R1", "usb_drv held", 16'(usb_drv_o), 16'(want[3:2]));
    @(posedge clk); #1;
    // R12: groups in low or Hi-Z drive do not pulse while the clock is high
    if (!act_m(want[10:9])) chk("R12", "host_ck idle", 16'(host_ck_o), 16'd0);
    if (!act_m(want[6:5]))  chk("R12", "io_ck idle", 16'(io_ck_o), 16'd0);
    if (!act_m(want[3:2]))  chk("R12", "usb_ck idle", 16'(usb_ck_o), 16'd0);
    if (!act_m(want[1:0]))  chk("R12", "ref_ck idle", 16'(ref_ck_o), 16'd0);
  endtask

  initial begin
    scenario("R3", 4'b0000, 0);
    scenario("R3", 4'b1001, 1);
    scenario("R4", 4'b0010, 0);
    scenario("R4", 4'b1011, 0);
    scenario("R5", 4'b0100, 0);
    scenario("R5", 4'b1100, 1);
    scenario("R6", 4'b0110, 0);
    scenario("R7", 4'b1110, 0);
    scenario("R8", 4'b0101, 0);
    scenario("R8", 4'b1111, 1);
    run_cycles(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(64'd200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule